// File: doc/BRIEF.md
# SDRAM Bank Configuration and Decode Unit

This block is the configuration side of a four-bank SDRAM controller. Software reaches its registers indirectly through two bus ports. A write to the address port stores a 32-bit sub-address, and the data port then reads or writes the register that this sub-address selects. The registers are two error status words, an error address, the global configuration and status words, the refresh and power-management words, one configuration word per bank, the ECC configuration and the ECC error status. Each register keeps only its writable fields.

From the bank configuration words, the block decodes an incoming 32-bit physical address. Each bank claims a naturally aligned, power-of-two window. The outputs are a hit vector, an index for the lowest-numbered bank that hits, and an any-hit flag. An interrupt output reports a nonzero ECC error status. Command sequencing, refresh generation and the data path are handled elsewhere.

Top module: `sdram_cfg_decode`

## Requirements
- R1: After reset, the address port reads 0 and the registers read as follows: configuration 0x00800000, refresh 0x05F00000, power-management 0x07C00000, status 0, ECC error status 0, ECC configuration 0 and error address 0. The decode outputs are all 0 and `ecc_irq` is 0.
- R2: A write to bus address BASE (default 0x10) stores the full 32-bit sub-address, and a read of BASE returns it. A read of any bus address other than BASE and BASE+1 returns 0, and a write to such an address changes no register.
- R3: A write to configuration (sub-address 0x20) stores the value ANDed with 0xFFE00000. Status (sub-address 0x24) ignores writes and changes only on configuration writes.
- R4: When configuration bit 31 goes from 0 to 1, status bit 31 clears. When it goes from 1 to 0, status bit 31 sets. When configuration bit 30 rises, status bit 30 sets, and when it falls, status bit 30 clears. All other status bits read 0.
- R5: Refresh (0x30) stores the value under mask 0x3FF80000. Power-management (0x34) stores (value AND 0xF8000000) OR 0x07C00000. ECC configuration (0x94) keeps mask 0x00F00000. Error address (0x10) stores the full value. The two error status words (0x00, 0x08) clear the bits written as 1. The timing sub-address (0x80) always reads 0xFFFFFFFF.
- R6: Bank configuration words sit at sub-address 0x40 + 4*n. A write stores the value ANDed with 0xFFDEE001. In this word, bits 31:23 hold the base, bits 19:17 hold the size code, and bit 0 is the bank enable.
- R7: A sub-address with no register reads 0xFFFFFFFF, and a write to it changes no register.
- R8: Bank n hits only when configuration bit 31 is 1, its own bit 0 is 1 and its size code c is below 7. Its window size is 4 MiB << c. It hits when the address bits above the window size equal the same bits of {base, 23'b0}.
- R9: `bank_any` is 1 when any bit of `bank_hit` is 1. `bank_idx` gives the lowest-numbered bank that hits, and reads 0 when no bank hits.
- R10: ECC error status (0x98) stores the value under mask 0xFFF0F000. `ecc_irq` is 1 exactly while this stored value is nonzero, so a write whose masked value is zero lowers it.
- R11: A bank whose size code is 7 never hits, even when it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the bus port named by bus_addr |
| bus_addr | input | AW | Bus address; BASE selects the address port, BASE+1 the data port |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| phys_addr | input | 32 | Physical address to decode |
| bank_hit | output | NBANK | Per-bank hit vector |
| bank_idx | output | IW | Lowest-numbered hitting bank |
| bank_any | output | 1 | Any bank hits |
| ecc_irq | output | 1 | ECC error status is nonzero |

## Verification
The bench loads banks with overlapping windows, so the index must come from the lowest-numbered hit. A design that encoded the highest bit would report bank 3 where bank 0 wins. It probes addresses one byte past a window and inside the largest window. A wrong mask width there would either wrap addresses into a bank or drop valid ones. It writes all ones to a bank word, which yields the invalid size code 7, and checks that no hit appears. A design with a 3-bit shift that runs past 256 MiB would decode a spurious window there. It also walks the enable bit through rise, fall and rise again to catch status bit 31 stored with the wrong sense, and it writes an ECC value whose only set bits lie outside the mask to catch an interrupt raised on unmasked data.

// File: rtl/sdram_cfg_decode.sv
module sdram_cfg_decode #(
  parameter int AW    = 10,
  parameter int BASE  = 'h10,
  parameter int NBANK = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       phys_addr,
  output logic [NBANK-1:0]  bank_hit,
  output logic [(NBANK>1 ? $clog2(NBANK) : 1)-1:0] bank_idx,
  output logic              bank_any,
  output logic              ecc_irq
);
  localparam int IW = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam logic [AW-1:0] A_PORT = AW'(BASE);
  localparam logic [AW-1:0] D_PORT = AW'(BASE + 1);

  localparam logic [31:0] S_ERR0 = 32'h00, S_ERR1 = 32'h08, S_EADR = 32'h10;
  localparam logic [31:0] S_CFG  = 32'h20, S_STAT = 32'h24, S_RFSH = 32'h30;
  localparam logic [31:0] S_PWR  = 32'h34, S_BANK = 32'h40, S_ECFG = 32'h94;
  localparam logic [31:0] S_ESTS = 32'h98;

  logic [31:0] ind, err0, err1, eadr, cfg, rfsh, pwr, ecfg, ests;
  logic [1:0]  stat;
  logic [31:0] bcfg [NBANK];

  wire data_wr = bus_wr && (bus_addr == D_PORT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ind  <= '0;
      err0 <= '0;
      err1 <= '0;
      eadr <= '0;
      cfg  <= 32'h0080_0000;
      stat <= '0;
      rfsh <= 32'h05F0_0000;
      pwr  <= 32'h07C0_0000;
      ecfg <= '0;
      ests <= '0;
      for (int i = 0; i < NBANK; i++) bcfg[i] <= '0;
    end else if (bus_wr && bus_addr == A_PORT) begin
      ind <= bus_wdata;
    end else if (data_wr) begin
      case (ind)
        S_ERR0: err0 <= err0 & ~bus_wdata;
        S_ERR1: err1 <= err1 & ~bus_wdata;
        S_EADR: eadr <= bus_wdata;
        S_CFG: begin
          cfg <= bus_wdata & 32'hFFE0_0000;
          if (!cfg[31] && bus_wdata[31]) stat[1] <= 1'b0;
          else if (cfg[31] && !bus_wdata[31]) stat[1] <= 1'b1;
          if (!cfg[30] && bus_wdata[30]) stat[0] <= 1'b1;
          else if (cfg[30] && !bus_wdata[30]) stat[0] <= 1'b0;
        end
        S_RFSH: rfsh <= bus_wdata & 32'h3FF8_0000;
        S_PWR:  pwr  <= (bus_wdata & 32'hF800_0000) | 32'h07C0_0000;
        S_ECFG: ecfg <= bus_wdata & 32'h00F0_0000;
        S_ESTS: ests <= bus_wdata & 32'hFFF0_F000;
        default: begin
          for (int i = 0; i < NBANK; i++)
            if (ind == S_BANK + 32'(4 * i)) bcfg[i] <= bus_wdata & 32'hFFDE_E001;
        end
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_PORT) begin
      bus_rdata = ind;
    end else if (bus_addr == D_PORT) begin
      bus_rdata = 32'hFFFF_FFFF;
      case (ind)
        S_ERR0: bus_rdata = err0;
        S_ERR1: bus_rdata = err1;
        S_EADR: bus_rdata = eadr;
        S_CFG:  bus_rdata = cfg;
        S_STAT: bus_rdata = {stat, 30'd0};
        S_RFSH: bus_rdata = rfsh;
        S_PWR:  bus_rdata = pwr;
        S_ECFG: bus_rdata = ecfg;
        S_ESTS: bus_rdata = ests;
        default: ;
      endcase
      for (int i = 0; i < NBANK; i++)
        if (ind == S_BANK + 32'(4 * i)) bus_rdata = bcfg[i];
    end
  end

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    wire [2:0]  code = bcfg[g][19:17];
    wire [31:0] keep = 32'hFFFF_FFFF << (6'd22 + {3'd0, code});
    wire [31:0] diff = phys_addr ^ {bcfg[g][31:23], 23'd0};
    assign bank_hit[g] = cfg[31] & bcfg[g][0] & (code != 3'd7) & ((diff & keep) == 32'd0);
  end

  always_comb begin
    bank_idx = '0;
    for (int i = NBANK - 1; i >= 0; i--)
      if (bank_hit[i]) bank_idx = IW'(i);
  end

  assign bank_any = |bank_hit;
  assign ecc_irq  = (ests != 32'd0);
endmodule

// File: rtl/sdram_cfg_decode_chk.sv
module sdram_cfg_decode_chk #(
  parameter int AW    = 10,
  parameter int BASE  = 'h10,
  parameter int NBANK = 4,
  parameter int IW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [AW-1:0]    bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      ind,
  input logic [31:0]      cfg,
  input logic [1:0]       stat,
  input logic [NBANK-1:0] bank_hit,
  input logic [IW-1:0]    bank_idx,
  input logic             bank_any,
  input logic             ecc_irq
);
  localparam logic [AW-1:0] DP = AW'(BASE + 1);
  wire dwr    = bus_wr && (bus_addr == DP);
  wire cfg_wr = dwr && (ind == 32'h20);
  wire ecc_wr = dwr && (ind == 32'h98);
  wire [31:0] ecc_val = bus_wdata & 32'hFFF0_F000;

  assert_idx_hits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bank_any |-> bank_hit[bank_idx]);
  assert_idx_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bank_any |-> ((bank_hit & NBANK'((1 << bank_idx) - 1)) == '0));
  assert_gate_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg[31] |-> (bank_hit == '0));
  assert_en_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg[31] && bus_wdata[31]) |=> !stat[1]);
  assert_en_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg[31] && !bus_wdata[31]) |=> stat[1]);
  assert_stat_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(stat));
  assert_irq_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_wr && ecc_val == 32'd0) |=> !ecc_irq);
  assert_irq_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_wr && ecc_val != 32'd0) |=> ecc_irq);
endmodule

bind sdram_cfg_decode sdram_cfg_decode_chk #(.AW(AW), .BASE(BASE), .NBANK(NBANK), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .ind(ind), .cfg(cfg), .stat(stat), .bank_hit(bank_hit), .bank_idx(bank_idx),
  .bank_any(bank_any), .ecc_irq(ecc_irq)
);

// File: tb/sdram_cfg_decode_tb.sv
module sdram_cfg_decode_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam logic [AW-1:0] AP = 10'h10;
  localparam logic [AW-1:0] DP = 10'h11;

  logic clk = 0, rst_n = 0, bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, phys_addr = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  bank_hit;
  logic [1:0]  bank_idx;
  logic        bank_any, ecc_irq;

  sdram_cfg_decode u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .phys_addr(phys_addr),
    .bank_hit(bank_hit), .bank_idx(bank_idx), .bank_any(bank_any), .ecc_irq(ecc_irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef enum logic [1:0] {K_RD, K_DEC, K_IRQ} kind_t;
  typedef struct {
    kind_t       kind;
    logic [31:0] val;
    string       tag;
  } exp_t;

  exp_t q[$];
  int unsigned checks = 0, fails = 0;
  logic chk_en = 0;
  logic done = 0;

  always @(negedge clk) begin
    if (chk_en) begin
      if (q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL scoreboard: nothing expected, got %h expected none", bus_rdata);
      end else begin
        exp_t e;
        logic [31:0] obs;
        e = q.pop_front();
        case (e.kind)
          K_RD:    obs = bus_rdata;
          K_DEC:   obs = {25'd0, bank_any, bank_idx, bank_hit};
          default: obs = {31'd0, ecc_irq};
        endcase
        checks++;
        if (obs !== e.val) begin
          fails++;
          $display("FAIL %s: got %h expected %h", e.tag, obs, e.val);
        end
      end
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 0;
  endtask

  task automatic observe(input kind_t k, input logic [AW-1:0] a, input logic [31:0] pa,
                         input logic [31:0] v, input string tag);
    exp_t e;
    @(posedge clk); #1;
    bus_wr = 0; bus_addr = a; phys_addr = pa;
    e.kind = k; e.val = v; e.tag = tag;
    q.push_back(e);
    chk_en = 1;
    @(negedge clk); #1;
    chk_en = 0;
  endtask

  task automatic wsub(input logic [31:0] s, input logic [31:0] d);
    wr(AP, s);
    wr(DP, d);
  endtask

  task automatic rsub(input logic [31:0] s, input logic [31:0] v, input string tag);
    wr(AP, s);
    observe(K_RD, DP, 32'd0, v, tag);
  endtask

  task automatic dec(input logic [31:0] pa, input logic any, input logic [1:0] idx,
                     input logic [3:0] hit, input string tag);
    observe(K_DEC, AP, pa, {25'd0, any, idx, hit}, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    observe(K_RD, AP, 32'd0, 32'd0, "R1 address port reset");
    observe(K_IRQ, AP, 32'd0, 32'd0, "R1 irq reset");
    dec(32'h0010_0000, 0, 0, 4'b0000, "R1 decode reset");
    rsub(32'h20, 32'h0080_0000, "R1 cfg reset");
    rsub(32'h30, 32'h05F0_0000, "R1 refresh reset");
    rsub(32'h34, 32'h07C0_0000, "R1 power reset");
    rsub(32'h24, 32'h0, "R1 status reset");
    rsub(32'h98, 32'h0, "R1 ecc status reset");

    wr(AP, 32'hDEAD_BEEF);
    observe(K_RD, AP, 32'd0, 32'hDEAD_BEEF, "R2 address port readback");
    observe(K_RD, 10'h12, 32'd0, 32'd0, "R2 other bus address reads 0");
    wr(10'h12, 32'h1234_5678);
    observe(K_RD, AP, 32'd0, 32'hDEAD_BEEF, "R2 other bus write ignored");

    wsub(32'h30, 32'hFFFF_FFFF); rsub(32'h30, 32'h3FF8_0000, "R5 refresh mask");
    wsub(32'h34, 32'h0);         rsub(32'h34, 32'h07C0_0000, "R5 power fixed bits");
    wsub(32'h34, 32'hFFFF_FFFF); rsub(32'h34, 32'hFFC0_0000, "R5 power full");
    wsub(32'h94, 32'hFFFF_FFFF); rsub(32'h94, 32'h00F0_0000, "R5 ecc cfg mask");
    wsub(32'h10, 32'h1234_5678); rsub(32'h10, 32'h1234_5678, "R5 error address");
    wsub(32'h00, 32'hFFFF_FFFF); rsub(32'h00, 32'h0, "R5 error status 0 w1c");
    wsub(32'h08, 32'hFFFF_FFFF); rsub(32'h08, 32'h0, "R5 error status 1 w1c");
    wsub(32'h80, 32'h0);         rsub(32'h80, 32'hFFFF_FFFF, "R5 timing reads ones");

    wsub(32'h20, 32'hFFFF_FFFF); rsub(32'h20, 32'hFFE0_0000, "R3 cfg mask");
    rsub(32'h24, 32'h4000_0000, "R4 status after rise");
    wsub(32'h20, 32'h0);         rsub(32'h24, 32'h8000_0000, "R4 status after fall");
    wsub(32'h20, 32'h8000_0000); rsub(32'h24, 32'h0, "R4 status after re-enable");
    wsub(32'h24, 32'hFFFF_FFFF); rsub(32'h24, 32'h0, "R3 status write ignored");

    wsub(32'h04, 32'h0000_0000); rsub(32'h04, 32'hFFFF_FFFF, "R7 undefined reads ones");
    rsub(32'h20, 32'h8000_0000, "R7 undefined write no effect");

    wsub(32'h40, 32'hFFFF_FFFF); rsub(32'h40, 32'hFFDE_E001, "R6 bank mask");
    dec(32'hFFFF_FFFF, 0, 0, 4'b0000, "R11 code 7 no hit");
    dec(32'hFF80_0000, 0, 0, 4'b0000, "R11 code 7 base addr no hit");

    wsub(32'h40, 32'h0000_0001);
    wsub(32'h44, 32'h0104_0001);
    wsub(32'h48, 32'h100C_0001);
    wsub(32'h4C, 32'h0006_0001);
    rsub(32'h44, 32'h0104_0001, "R6 bank1 readback");
    dec(32'h0010_0000, 1, 0, 4'b1001, "R9 overlap lowest bank0");
    dec(32'h0050_0000, 1, 3, 4'b1000, "R8 32MiB window only");
    dec(32'h003F_FFFF, 1, 0, 4'b1001, "R8 top of 4MiB window");
    dec(32'h01FF_FFFC, 1, 1, 4'b1010, "R9 bank1 over bank3");
    dec(32'h0200_0000, 0, 0, 4'b0000, "R8 past windows no hit");
    dec(32'h1ABC_DEF0, 1, 2, 4'b0100, "R8 256MiB window");
    dec(32'h2000_0000, 0, 0, 4'b0000, "R8 past 256MiB window");

    wsub(32'h20, 32'h0);
    dec(32'h0010_0000, 0, 0, 4'b0000, "R8 global disable");
    wsub(32'h20, 32'h8000_0000);
    wsub(32'h40, 32'h0);
    dec(32'h0010_0000, 1, 3, 4'b1000, "R8 bank enable off");

    wsub(32'h98, 32'h000F_0FFF);
    observe(K_IRQ, AP, 32'd0, 32'd0, "R10 masked-out bits no irq");
    rsub(32'h98, 32'h0, "R10 masked-out bits stored 0");
    wsub(32'h98, 32'hFFFF_FFFF);
    observe(K_IRQ, AP, 32'd0, 32'd1, "R10 irq raised");
    rsub(32'h98, 32'hFFF0_F000, "R10 ecc status mask");
    wsub(32'h98, 32'h0);
    observe(K_IRQ, AP, 32'd0, 32'd0, "R10 irq lowered");

    repeat (2) @(posedge clk);
    finish_run();
  end
endmodule